// File: doc/BRIEF.md
# Seven-Segment Decoder with Blanking and Brightness Control

This block turns a 4-bit digit code into the seven drive signals of one seven-segment display position. Segment outputs are active high and registered, so they change only on a clock edge. A forced-dark input switches the whole digit off regardless of the code. A zero-suppression input darkens the digit only when its code is zero. A matching zero-suppression output tells the next less significant position whether it too may suppress a zero. Chaining these signals from the most significant position downward removes leading zeros from a number.

Brightness is set by an internal pulse-width generator. An 8-bit free-running counter is compared with an 8-bit level, and the segments may light only while the counter is below that level. A build-time parameter decides what codes 10 to 15 produce: a dark digit, or a distinct hexadecimal letter for each code.

Top module: `seg7_blank_decoder`

## Requirements
- R1: Codes 0 to 9 light the standard decimal glyphs. Segment bit 0 is a, bit 1 b, bit 2 c, bit 3 d, bit 4 e, bit 5 f, bit 6 g. 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F.
- R2: With `blank_n` at 0 when an edge samples it, every segment is 0 after that edge, whatever the code.
- R3: With `rbi_n` at 0, code 0 gives all segments 0 after the next edge. A nonzero code is shown as normal.
- R4: `rbo_n` is combinational and is 0 exactly when `rbi_n` is 0 and the code is 0. Otherwise it is 1.
- R5: With HEX_MODE=0, codes 10 to 15 give all segments 0.
- R6: With HEX_MODE=1, codes 10 to 15 show A=0x77, b=0x7C, C=0x39, d=0x5E, E=0x79, F=0x71.
- R7: An 8-bit counter advances by one every cycle and wraps from 255 to 0. A glyph is shown after an edge only if the counter value at that edge is below `level`. So level 0 is always dark, and level 255 is lit on 255 of every 256 cycles.
- R8: Segment outputs change only at a rising clock edge. A change of inputs between edges leaves them unchanged.
- R9: Reset (`rst_n` low, asynchronous) forces all segments to 0 and the counter to 0. The first edge after release uses counter value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| digit | input | 4 | Code to display |
| blank_n | input | 1 | Forced-dark input, active low |
| rbi_n | input | 1 | Zero-suppression input, active low |
| level | input | 8 | Brightness level |
| seg | output | 7 | Registered segments a..g on bits 0..6, active high |
| rbo_n | output | 1 | Zero-suppression output to the next lower digit, active low |

## Verification
The bench goes after the zero-suppression edge. A design that checked only `rbi_n` would blank nonzero digits, and one that ignored it would show the leading zero. The bench also walks the brightness extremes. Level 0 must stay dark for a full counter period, and level 255 must go dark at counter value 255 only; an off-by-one compare shows up as a lit or dark cycle in the wrong place. It checks that codes 10 to 15 differ between the two HEX_MODE builds, and that the counter restarts at zero after a mid-run reset, which a design without a counter reset would get wrong in the first cycles after release.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;
  localparam seg_t SEG_DARK = '0;

  // decimal glyphs, segment a on bit 0 through g on bit 6
  function automatic seg_t decimal_glyph(input logic [3:0] code);
    seg_t g;
    case (code)
      4'd0: g = 7'h3F;
      4'd1: g = 7'h06;
      4'd2: g = 7'h5B;
      4'd3: g = 7'h4F;
      4'd4: g = 7'h66;
      4'd5: g = 7'h6D;
      4'd6: g = 7'h7D;
      4'd7: g = 7'h07;
      4'd8: g = 7'h7F;
      4'd9: g = 7'h6F;
      default: g = SEG_DARK;
    endcase
    return g;
  endfunction

  // letter glyphs for codes 10..15
  function automatic seg_t letter_glyph(input logic [3:0] code);
    seg_t g;
    case (code)
      4'd10: g = 7'h77;
      4'd11: g = 7'h7C;
      4'd12: g = 7'h39;
      4'd13: g = 7'h5E;
      4'd14: g = 7'h79;
      4'd15: g = 7'h71;
      default: g = SEG_DARK;
    endcase
    return g;
  endfunction

  function automatic logic is_letter(input logic [3:0] code);
    return code > 4'd9;
  endfunction
endpackage

// File: rtl/seg7_glyph.sv
module seg7_glyph
  import seg7_pkg::*;
#(
  parameter bit HEX_MODE = 1'b0
) (
  input  logic [3:0] code,
  output seg_t       glyph,
  output logic       letter_code
);
  assign letter_code = is_letter(code);

  generate
    if (HEX_MODE) begin : g_hex
      assign glyph = letter_code ? letter_glyph(code) : decimal_glyph(code);
    end else begin : g_dec
      assign glyph = letter_code ? SEG_DARK : decimal_glyph(code);
    end
  endgenerate
endmodule

// File: rtl/seg7_pwm.sv
module seg7_pwm #(
  parameter int LEVEL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEVEL_W-1:0] level,
  output logic               pwm_on,
  output logic [LEVEL_W-1:0] phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end

  assign pwm_on = phase < level;

  // R7: counter steps by one each cycle, wrapping naturally
  a_r7_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != '1) |=> (phase == $past(phase) + 1'b1));
  a_r7_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == '1) |=> (phase == '0));
endmodule

// File: rtl/seg7_ripple.sv
module seg7_ripple #(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] digit,
  input  logic               rbi_n,
  output logic               rbo_n,
  output logic               zero_suppress
);
  assign zero_suppress = !rbi_n && (digit == '0);
  assign rbo_n         = !zero_suppress;
endmodule

// File: rtl/seg7_blank_decoder.sv
module seg7_blank_decoder
  import seg7_pkg::*;
#(
  parameter bit HEX_MODE = 1'b0,
  parameter int DIGIT_W  = 4,
  parameter int LEVEL_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIGIT_W-1:0] digit,
  input  logic               blank_n,
  input  logic               rbi_n,
  input  logic [LEVEL_W-1:0] level,
  output logic [SEG_W-1:0]   seg,
  output logic               rbo_n
);
  seg_t               glyph;
  logic               letter_code;
  logic               zero_suppress;
  logic               pwm_on;
  logic [LEVEL_W-1:0] phase;
  logic               force_dark;
  seg_t               seg_d;
  seg_t               seg_q;

  seg7_glyph #(.HEX_MODE(HEX_MODE)) u_glyph (
    .code        (digit[3:0]),
    .glyph       (glyph),
    .letter_code (letter_code)
  );

  seg7_ripple #(.DIGIT_W(DIGIT_W)) u_ripple (
    .digit         (digit),
    .rbi_n         (rbi_n),
    .rbo_n         (rbo_n),
    .zero_suppress (zero_suppress)
  );

  seg7_pwm #(.LEVEL_W(LEVEL_W)) u_pwm (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (level),
    .pwm_on (pwm_on),
    .phase  (phase)
  );

  assign force_dark = !blank_n || zero_suppress || !pwm_on;
  assign seg_d      = force_dark ? SEG_DARK : glyph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seg_q <= SEG_DARK;
    else        seg_q <= seg_d;
  end

  assign seg = seg_q;

  // R2: forced-dark input darkens the next output
  a_r2_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> (seg == '0));
  // R3: suppressed zero is dark on the next output
  a_r3_zero_dark: assert property (@(posedge clk) disable iff (!rst_n)
    zero_suppress |=> (seg == '0));
  // R3: nonzero decimal digit survives a low rbi_n
  a_r3_nonzero_shown: assert property (@(posedge clk) disable iff (!rst_n)
    (!rbi_n && blank_n && pwm_on && !letter_code && digit != '0) |=> (seg != '0));
  // R4: rbo_n can only go low while rbi_n is low
  a_r4_rbo_needs_rbi: assert property (@(posedge clk) disable iff (!rst_n)
    rbi_n |-> rbo_n);
  // R7: pwm off phase gives a dark output
  a_r7_pwm_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_on |=> (seg == '0));
  // R7: level zero is always dark
  a_r7_level_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |=> (seg == '0));

  generate
    if (!HEX_MODE) begin : g_dec_chk
      // R5: letter codes are dark without hex mode
      a_r5_letters_dark: assert property (@(posedge clk) disable iff (!rst_n)
        letter_code |=> (seg == '0));
    end else begin : g_hex_chk
      // R6: letter codes light something in hex mode when enabled
      a_r6_letters_lit: assert property (@(posedge clk) disable iff (!rst_n)
        (letter_code && blank_n && pwm_on) |=> (seg != '0));
    end
  endgenerate
endmodule

// File: tb/seg7_blank_decoder_tb.sv
`timescale 1ns/1ps
module seg7_blank_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] digit = 4'd0;
  logic       blank_n = 1'b1;
  logic       rbi_n = 1'b1;
  logic [7:0] level = 8'd255;
  logic [6:0] seg, seg_hex;
  logic       rbo_n, rbo_n_hex;

  int checks = 0;
  int fails  = 0;
  int ecount = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) ecount <= rst_n ? ecount + 1 : 0;

  seg7_blank_decoder #(.HEX_MODE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .digit(digit), .blank_n(blank_n),
    .rbi_n(rbi_n), .level(level), .seg(seg), .rbo_n(rbo_n));

  seg7_blank_decoder #(.HEX_MODE(1'b1)) u_dut_hex (
    .clk(clk), .rst_n(rst_n), .digit(digit), .blank_n(blank_n),
    .rbi_n(rbi_n), .level(level), .seg(seg_hex), .rbo_n(rbo_n_hex));

  // per-segment sets of codes that light it, bit n = code n
  localparam logic [15:0] LIT_A = 16'hD7ED;
  localparam logic [15:0] LIT_B = 16'h279F;
  localparam logic [15:0] LIT_C = 16'h2FFB;
  localparam logic [15:0] LIT_D = 16'h7B6D;
  localparam logic [15:0] LIT_E = 16'hFD45;
  localparam logic [15:0] LIT_F = 16'hDF71;
  localparam logic [15:0] LIT_G = 16'hEF7C;

  function automatic logic [6:0] expect_seg(input logic [3:0] d, input logic bn,
      input logic rn, input logic [7:0] lvl, input int used, input bit hex);
    if (!bn || (!rn && d == 4'd0) || used >= int'(lvl) || (!hex && d >= 4'd10))
      return 7'h00;
    return {LIT_G[d], LIT_F[d], LIT_E[d], LIT_D[d], LIT_C[d], LIT_B[d], LIT_A[d]};
  endfunction

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at t=%0t", req, act, exp_v, $time);
    end
  endtask

  int used_cnt;
  task automatic check_outputs(input string req);
    used_cnt = (ecount - 1) % 256;
    chk(req, seg, expect_seg(digit, blank_n, rbi_n, level, used_cnt, 1'b0));
    chk(req, seg_hex, expect_seg(digit, blank_n, rbi_n, level, used_cnt, 1'b1));
  endtask

  typedef struct packed {
    logic [3:0] d;
    logic       bn;
    logic       rn;
    logic [7:0] lvl;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 1'b1, 1'b1, 8'd255}, '{4'd1, 1'b1, 1'b1, 8'd255},
    '{4'd2, 1'b1, 1'b1, 8'd255}, '{4'd3, 1'b1, 1'b1, 8'd255},
    '{4'd4, 1'b1, 1'b1, 8'd255}, '{4'd5, 1'b1, 1'b1, 8'd255},
    '{4'd6, 1'b1, 1'b1, 8'd255}, '{4'd7, 1'b1, 1'b1, 8'd255},
    '{4'd8, 1'b1, 1'b1, 8'd255}, '{4'd9, 1'b1, 1'b1, 8'd255},
    '{4'd10, 1'b1, 1'b1, 8'd255}, '{4'd11, 1'b1, 1'b1, 8'd255},
    '{4'd12, 1'b1, 1'b1, 8'd255}, '{4'd13, 1'b1, 1'b1, 8'd255},
    '{4'd14, 1'b1, 1'b1, 8'd255}, '{4'd15, 1'b1, 1'b1, 8'd255},
    '{4'd8, 1'b0, 1'b1, 8'd255}, '{4'd0, 1'b0, 1'b1, 8'd255},
    '{4'd13, 1'b0, 1'b1, 8'd255}, '{4'd0, 1'b1, 1'b0, 8'd255},
    '{4'd5, 1'b1, 1'b0, 8'd255}, '{4'd12, 1'b1, 1'b0, 8'd255},
    '{4'd0, 1'b1, 1'b1, 8'd255}, '{4'd7, 1'b1, 1'b1, 8'd0},
    '{4'd9, 1'b1, 1'b1, 8'd200}, '{4'd1, 1'b0, 1'b0, 8'd255}
  };

  int lit;
  logic [6:0] held;

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9 reset dark", seg, 7'h00);
    chk("R9 reset dark hex", seg_hex, 7'h00);
    rst_n = 1'b1;

    // R1 R2 R3 R5 R6: vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      digit = VECS[i].d; blank_n = VECS[i].bn; rbi_n = VECS[i].rn; level = VECS[i].lvl;
      #1;
      // R4: rbo_n combinational
      chk("R4 rbo_n", {6'd0, rbo_n}, {6'd0, !(!VECS[i].rn && VECS[i].d == 4'd0)});
      @(negedge clk);
      check_outputs("R1/R2/R3/R5/R6 vector");
    end

    // R4: rbo_n for all codes with rbi_n low and high
    for (int d = 0; d < 16; d++) begin
      @(negedge clk);
      digit = 4'(d); rbi_n = 1'b0; blank_n = 1'b1; level = 8'd255;
      #1 chk("R4 rbo_n low rbi", {6'd0, rbo_n}, {6'd0, (d != 0)});
      rbi_n = 1'b1;
      #1 chk("R4 rbo_n high rbi", {6'd0, rbo_n}, 7'd1);
    end

    // R8: input change between edges leaves outputs unchanged
    @(negedge clk);
    digit = 4'd3; rbi_n = 1'b1; blank_n = 1'b1; level = 8'd255;
    @(negedge clk);
    held = seg;
    digit = 4'd4;
    #1 chk("R8 hold between edges", seg, held);
    blank_n = 1'b0;
    #1 chk("R8 hold after blank change", seg, held);
    @(negedge clk);
    check_outputs("R8 update at edge");

    // R7: level 0 dark over a full period
    blank_n = 1'b1; digit = 4'd8; level = 8'd0;
    lit = 0;
    for (int k = 0; k < 260; k++) begin
      @(negedge clk);
      if (k > 0 && seg != 7'h00) lit++;
    end
    chk("R7 level 0 lit count", 7'(lit), 7'd0);

    // R7: level 255 lit 255 of 256, matching the model every cycle
    level = 8'd255;
    @(negedge clk);
    lit = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      if (seg == 7'h7F) lit++;
      check_outputs("R7 level 255 cycle");
    end
    checks++;
    if (lit != 255) begin
      fails++;
      $display("FAIL R7 level 255 lit cycles: actual %0d expected 255", lit);
    end

    // R7: level 128 gives half duty
    level = 8'd128;
    @(negedge clk);
    lit = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      if (seg != 7'h00) lit++;
    end
    checks++;
    if (lit != 128) begin
      fails++;
      $display("FAIL R7 level 128 lit cycles: actual %0d expected 128", lit);
    end

    // R9: mid-run reset clears segments and counter
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R9 async reset dark", seg, 7'h00);
    level = 8'd1; digit = 4'd8;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 first cycle uses counter 0", seg, 7'h7F);
    @(negedge clk);
    chk("R9 second cycle counter 1 dark", seg, 7'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule